// File: doc/BRIEF.md
# Host Programmed-I/O Command Sequencer

This block is a small register file that lets host software launch one programmed-I/O transaction at a time toward a touch controller. The controller sits behind either an SPI port or an I2C port. Software first loads a target address, a byte count and an opcode, and optionally places outgoing data words in a data window. It then sets a launch bit in the same write that carries the opcode.

The block validates the opcode against the port type, which is a static input. If the opcode is legal it raises a busy flag and hands the command to a bus engine. Here the engine is a fixed-latency stand-in for the real serializers. It spends one cycle per outgoing data word and fills the data window with read data, one word per cycle. When it finishes, busy drops and a sticky done flag rises. For reads, the byte-count field is replaced by the number of bytes actually delivered.

Illegal commands never reach the engine. Instead they set the error and done flags together. A completion interrupt follows the done flag when it is enabled. The I2C write-then-read opcode takes its outgoing length from a separate register, which also carries an enable bit.

Top module: `pio_cmd_regs`

## Requirements
- R1: After synchronous reset, the status, control, target and write-then-read registers read as zero and `irq` is low.
- R2: The status word (address 0) holds busy in bit 0, error in bit 1 and done in bit 2. Writing 1 to bit 1 or bit 2 clears that flag. Writing 0 to either has no effect, and busy cannot be written.
- R3: A launch is a write to the control word (address 1) that sets bit 31, with a legal opcode in bits 20:16. It sets busy and clears error and done. Busy stays high until the engine finishes, and the engine writes the window only while busy.
- R4: For a read opcode, the delivered length is min(requested bytes, 4*DATA_WORDS), where the requested bytes come from control bits 7:0. The delivered length is written back to control bits 7:0. Window word i, for i < ceil(length/4), then reads {target[15:0], opcode as 8 bits, i as 8 bits}.
- R5: Write opcodes leave the byte-count field and the data window contents unchanged.
- R6: While busy, writes to the control, target (address 2) and write-then-read (address 3) registers are ignored, including a second launch.
- R7: On the SPI port (`port_i2c`=0), only opcodes 0x04 (read) and 0x06 (write) are legal. On the I2C port, only 0x12 and 0x14 (reads), 0x13 and 0x18 (writes) and 0x1C (write-then-read) are legal. A launch with any other opcode sets error and done and leaves busy low.
- R8: Opcode 0x1C is legal only when bit 31 of the write-then-read register is set. Its outgoing length is taken from bits 7:0 of that register, and its read follows R4.
- R9: `irq` is high exactly while done is set and the interrupt enable (control bit 24) is set. It falls in the same cycle as a clear of done.
- R10: Host writes to the window (addresses 8 to 8+DATA_WORDS-1) take effect when idle and are ignored while busy.
- R11: Done is set on the rising edge that lies LAT_CYC+1+nw+nr edges after the edge that captured the launch. Here nw is the number of outgoing words and nr the number of read words. A write-one-to-clear landing on that same edge loses: done stays set.
- R12: The launch bit always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_i2c | input | 1 | Port type: 0 = SPI, 1 = I2C |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Completion interrupt |

## Verification
The critical coincidence is the engine's completion and a software write-one-to-clear of the status word on the same clock edge. The bench counts the cycles of a 32-byte read from the launch edge and times its clear write to land on the completion edge. It then expects done still set and the interrupt high. A second coincidence is a launch or window write arriving while busy. The bench issues both in mid-transfer and checks afterwards that the command fields, target and window words reflect only the first transaction.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // register word addresses
  localparam int A_STAT = 0;
  localparam int A_CTRL = 1;
  localparam int A_TGT  = 2;
  localparam int A_WRRD = 3;

  // status bits
  localparam int B_BUSY = 0;
  localparam int B_ERR  = 1;
  localparam int B_DONE = 2;

  // control fields
  localparam int OPW     = 5;
  localparam int OP_LSB  = 16;
  localparam int B_IE    = 24;
  localparam int B_GO    = 31;
  localparam int B_WR_EN = 31;

  typedef enum logic [OPW-1:0] {
    OP_SPI_RD = 5'h04,
    OP_SPI_WR = 5'h06,
    OP_SUB_RD = 5'h12,
    OP_SUB_WR = 5'h13,
    OP_DEV_RD = 5'h14,
    OP_DEV_WR = 5'h18,
    OP_WR_RD  = 5'h1C
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_DRAIN, S_FILL, S_FIN
  } eng_st_e;
endpackage

// File: rtl/pio_op_check.sv
module pio_op_check
  import pio_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic           port_i2c,
  input  logic           wrrd_en,
  output logic           ok,
  output logic           is_rd,
  output logic           is_wr,
  output logic           is_wrrd
);
  always_comb begin
    ok      = 1'b0;
    is_rd   = 1'b0;
    is_wr   = 1'b0;
    is_wrrd = 1'b0;
    case (op)
      OP_SPI_RD: begin ok = !port_i2c; is_rd = 1'b1; end
      OP_SPI_WR: begin ok = !port_i2c; is_wr = 1'b1; end
      OP_SUB_RD,
      OP_DEV_RD: begin ok = port_i2c;  is_rd = 1'b1; end
      OP_SUB_WR,
      OP_DEV_WR: begin ok = port_i2c;  is_wr = 1'b1; end
      OP_WR_RD: begin
        ok      = port_i2c && wrrd_en;
        is_rd   = 1'b1;
        is_wr   = 1'b1;
        is_wrrd = 1'b1;
      end
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/pio_win_ram.sv
module pio_win_ram #(
  parameter  int DW    = 32,
  parameter  int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pio_bus_stub.sv
module pio_bus_stub
  import pio_pkg::*;
#(
  parameter  int DW      = 32,
  parameter  int DEPTH   = 8,
  parameter  int LAT_CYC = 16,
  parameter  int BC_W    = 8,
  parameter  int TA_W    = 16,
  localparam int AW      = $clog2(DEPTH),
  localparam int CW      = $clog2(LAT_CYC + 1),
  localparam int BUF_B   = DEPTH * 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            is_rd,
  input  logic [OPW-1:0]  op,
  input  logic [TA_W-1:0] tgt,
  input  logic [BC_W-1:0] req_bc,
  input  logic [BC_W-1:0] send_bc,
  output logic            we,
  output logic [AW-1:0]   waddr,
  output logic [DW-1:0]   wdata,
  output logic            fin,
  output logic [BC_W-1:0] act_bc
);
  eng_st_e         st;
  logic [CW-1:0]   cnt;
  logic [AW:0]     idx, n_rd, n_wr;
  logic            rd_q;
  logic [OPW-1:0]  op_q;
  logic [TA_W-1:0] tgt_q;
  logic [BC_W-1:0] act_q, rd_bytes, wr_bytes;

  // clamp lengths to the window size
  always_comb begin
    if (int'(req_bc) > BUF_B) rd_bytes = BC_W'(BUF_B);
    else                      rd_bytes = req_bc;
    if (int'(send_bc) > BUF_B) wr_bytes = BC_W'(BUF_B);
    else                       wr_bytes = send_bc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      n_rd  <= '0;
      n_wr  <= '0;
      rd_q  <= 1'b0;
      op_q  <= '0;
      tgt_q <= '0;
      act_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st    <= S_WAIT;
          cnt   <= CW'(LAT_CYC - 1);
          rd_q  <= is_rd;
          op_q  <= op;
          tgt_q <= tgt;
          n_rd  <= is_rd ? (AW+1)'((int'(rd_bytes) + 3) / 4) : '0;
          n_wr  <= (AW+1)'((int'(wr_bytes) + 3) / 4);
          act_q <= is_rd ? rd_bytes : req_bc;
        end
        S_WAIT: begin
          if (cnt == '0) begin
            idx <= '0;
            if (n_wr != '0)                  st <= S_DRAIN;
            else if (rd_q && (n_rd != '0))   st <= S_FILL;
            else                             st <= S_FIN;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_DRAIN: begin
          if (idx == n_wr - 1'b1) begin
            idx <= '0;
            st  <= (rd_q && (n_rd != '0)) ? S_FILL : S_FIN;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_FILL: begin
          if (idx == n_rd - 1'b1) st <= S_FIN;
          idx <= idx + 1'b1;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign we     = (st == S_FILL);
  assign waddr  = idx[AW-1:0];
  assign wdata  = DW'({16'(tgt_q), 8'(op_q), 8'(idx)});
  assign fin    = (st == S_FIN);
  assign act_bc = act_q;
endmodule

// File: rtl/pio_cmd_regs.sv
module pio_cmd_regs
  import pio_pkg::*;
#(
  parameter  int ADDR_W     = 5,
  parameter  int DATA_WORDS = 8,
  parameter  int WIN_BASE   = 8,
  parameter  int LAT_CYC    = 16,
  parameter  int BC_W       = 8,
  parameter  int TA_W       = 16,
  localparam int DW         = 32,
  localparam int WIN_AW     = $clog2(DATA_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_i2c,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);
  // state
  logic            busy_q, err_q, done_q, ie_q, irq_q;
  logic [BC_W-1:0] bc_q, wbc_q;
  logic [OPW-1:0]  op_q;
  logic [TA_W-1:0] tgt_q;
  logic            wrrd_en_q;
  logic [DW-1:0]   reg_rd_q;
  logic            sel_win_q;

  // decode
  logic stat_wr, ctrl_wr, tgt_wr, wrrd_wr, in_win, host_we;
  logic go_req, launch_ok, bad_go;
  logic [WIN_AW-1:0] win_idx;

  assign in_win  = (int'(bus_addr) >= WIN_BASE) && (int'(bus_addr) < WIN_BASE + DATA_WORDS);
  assign win_idx = WIN_AW'(bus_addr - ADDR_W'(WIN_BASE));
  assign stat_wr = bus_wr && (bus_addr == ADDR_W'(A_STAT));
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign tgt_wr  = bus_wr && (bus_addr == ADDR_W'(A_TGT));
  assign wrrd_wr = bus_wr && (bus_addr == ADDR_W'(A_WRRD));
  assign host_we = bus_wr && in_win && !busy_q;

  // opcode legality, judged on the opcode being written with go
  logic [OPW-1:0] new_op;
  logic chk_ok, chk_rd, chk_wr, chk_wrrd;
  assign new_op = bus_wdata[OP_LSB +: OPW];

  pio_op_check u_chk_op (
    .op      (new_op),
    .port_i2c(port_i2c),
    .wrrd_en (wrrd_en_q),
    .ok      (chk_ok),
    .is_rd   (chk_rd),
    .is_wr   (chk_wr),
    .is_wrrd (chk_wrrd)
  );

  assign go_req    = ctrl_wr && bus_wdata[B_GO] && !busy_q;
  assign launch_ok = go_req && chk_ok;
  assign bad_go    = go_req && !chk_ok;

  // engine
  logic            eng_we, eng_fin;
  logic [WIN_AW-1:0] eng_waddr;
  logic [DW-1:0]   eng_wdata;
  logic [BC_W-1:0] eng_act, new_bc, send_bc;

  assign new_bc  = bus_wdata[BC_W-1:0];
  assign send_bc = !chk_wr ? '0 : (chk_wrrd ? wbc_q : new_bc);

  logic eng_is_rd_q;

  pio_bus_stub #(
    .DW(DW), .DEPTH(DATA_WORDS), .LAT_CYC(LAT_CYC), .BC_W(BC_W), .TA_W(TA_W)
  ) u_eng (
    .clk    (clk),
    .rst    (rst),
    .start  (launch_ok),
    .is_rd  (chk_rd),
    .op     (new_op),
    .tgt    (tgt_q),
    .req_bc (new_bc),
    .send_bc(send_bc),
    .we     (eng_we),
    .waddr  (eng_waddr),
    .wdata  (eng_wdata),
    .fin    (eng_fin),
    .act_bc (eng_act)
  );

  // window memory: engine owns the write port while busy
  logic              ram_we;
  logic [WIN_AW-1:0] ram_waddr;
  logic [DW-1:0]     ram_wdata, ram_q;

  assign ram_we    = eng_we || host_we;
  assign ram_waddr = eng_we ? eng_waddr : win_idx;
  assign ram_wdata = eng_we ? eng_wdata : bus_wdata;

  pio_win_ram #(.DW(DW), .DEPTH(DATA_WORDS)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .raddr(win_idx),
    .rdata(ram_q)
  );

  // flag next state: set events outrank write-one-to-clear
  logic n_busy, n_err, n_done, n_ie;
  always_comb begin
    n_busy = busy_q;
    n_err  = err_q;
    n_done = done_q;
    if (stat_wr) begin
      if (bus_wdata[B_ERR])  n_err  = 1'b0;
      if (bus_wdata[B_DONE]) n_done = 1'b0;
    end
    if (launch_ok) begin
      n_busy = 1'b1;
      n_err  = 1'b0;
      n_done = 1'b0;
    end
    if (bad_go) begin
      n_err  = 1'b1;
      n_done = 1'b1;
    end
    if (eng_fin) begin
      n_busy = 1'b0;
      n_done = 1'b1;
    end
    n_ie = (ctrl_wr && !busy_q) ? bus_wdata[B_IE] : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      err_q       <= 1'b0;
      done_q      <= 1'b0;
      ie_q        <= 1'b0;
      irq_q       <= 1'b0;
      bc_q        <= '0;
      op_q        <= '0;
      tgt_q       <= '0;
      wbc_q       <= '0;
      wrrd_en_q   <= 1'b0;
      eng_is_rd_q <= 1'b0;
    end else begin
      busy_q <= n_busy;
      err_q  <= n_err;
      done_q <= n_done;
      ie_q   <= n_ie;
      irq_q  <= n_ie && n_done;
      if (ctrl_wr && !busy_q) begin
        bc_q <= new_bc;
        op_q <= new_op;
      end
      if (launch_ok) eng_is_rd_q <= chk_rd;
      if (eng_fin && eng_is_rd_q) bc_q <= eng_act;
      if (tgt_wr && !busy_q) tgt_q <= bus_wdata[TA_W-1:0];
      if (wrrd_wr && !busy_q) begin
        wbc_q     <= bus_wdata[BC_W-1:0];
        wrrd_en_q <= bus_wdata[B_WR_EN];
      end
    end
  end

  // register read path
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(A_STAT)) begin
      rd_mux[B_BUSY] = busy_q;
      rd_mux[B_ERR]  = err_q;
      rd_mux[B_DONE] = done_q;
    end else if (bus_addr == ADDR_W'(A_CTRL)) begin
      rd_mux[BC_W-1:0]        = bc_q;
      rd_mux[OP_LSB +: OPW]   = op_q;
      rd_mux[B_IE]            = ie_q;
    end else if (bus_addr == ADDR_W'(A_TGT)) begin
      rd_mux[TA_W-1:0] = tgt_q;
    end else if (bus_addr == ADDR_W'(A_WRRD)) begin
      rd_mux[BC_W-1:0] = wbc_q;
      rd_mux[B_WR_EN]  = wrrd_en_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q  <= '0;
      sel_win_q <= 1'b0;
    end else if (bus_rd) begin
      reg_rd_q  <= rd_mux;
      sel_win_q <= in_win;
    end
  end

  assign bus_rdata = sel_win_q ? ram_q : reg_rd_q;
  assign irq       = irq_q;
endmodule

// File: rtl/pio_cmd_regs_chk.sv
module pio_cmd_regs_chk
  import pio_pkg::*;
#(
  parameter int BC_W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           busy_q,
  input logic           err_q,
  input logic           done_q,
  input logic           ie_q,
  input logic           irq,
  input logic           ctrl_wr,
  input logic [OPW-1:0] op_q,
  input logic [BC_W-1:0] bc_q,
  input logic           launch_ok,
  input logic           bad_go,
  input logic           eng_fin,
  input logic           eng_we,
  input logic           host_we
);
  p_launch_busy_r3: assert property (@(posedge clk) disable iff (rst)
    launch_ok |=> busy_q && !done_q && !err_q);

  p_eng_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !eng_we);

  p_go_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && ctrl_wr && !eng_fin) |=> busy_q && $stable(op_q) && $stable(bc_q));

  p_bad_op_r7: assert property (@(posedge clk) disable iff (rst)
    bad_go |=> err_q && done_q && !busy_q);

  p_irq_on_r9: assert property (@(posedge clk) disable iff (rst)
    (done_q && ie_q) |-> irq);

  p_irq_off_r9: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> !irq);

  p_one_writer_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({eng_we, host_we}));

  p_fin_done_r11: assert property (@(posedge clk) disable iff (rst)
    eng_fin |=> done_q && !busy_q);
endmodule

bind pio_cmd_regs pio_cmd_regs_chk #(.BC_W(BC_W)) u_regs_chk (
  .clk      (clk),
  .rst      (rst),
  .busy_q   (busy_q),
  .err_q    (err_q),
  .done_q   (done_q),
  .ie_q     (ie_q),
  .irq      (irq),
  .ctrl_wr  (ctrl_wr),
  .op_q     (op_q),
  .bc_q     (bc_q),
  .launch_ok(launch_ok),
  .bad_go   (bad_go),
  .eng_fin  (eng_fin),
  .eng_we   (eng_we),
  .host_we  (host_we)
);

// File: tb/tb_pio_cmd_regs.sv
`timescale 1ns/1ps
module tb_pio_cmd_regs;
  localparam int LAT = 16;
  localparam int NW  = 8;

  logic        clk = 1'b0;
  logic        rst, port_i2c, bus_wr, bus_rd;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pio_cmd_regs #(.LAT_CYC(LAT), .DATA_WORDS(NW)) dut (
    .clk(clk), .rst(rst), .port_i2c(port_i2c), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // vector: {port, wrrd_en, op[7:0], bc[7:0], tgt[15:0], exp_err, exp_bc[7:0]}
  localparam int NV = 9;
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h04, 8'd12, 16'h1234, 1'b0, 8'd12},
    {1'b0, 1'b0, 8'h06, 8'd16, 16'h2222, 1'b0, 8'd16},
    {1'b0, 1'b0, 8'h14, 8'd8,  16'h3333, 1'b1, 8'd8},
    {1'b1, 1'b0, 8'h14, 8'd40, 16'hBEEF, 1'b0, 8'd32},
    {1'b1, 1'b0, 8'h1C, 8'd8,  16'h4444, 1'b1, 8'd8},
    {1'b1, 1'b1, 8'h1C, 8'd5,  16'h0042, 1'b0, 8'd5},
    {1'b1, 1'b0, 8'h12, 8'd4,  16'h5A5A, 1'b0, 8'd4},
    {1'b1, 1'b0, 8'h06, 8'd4,  16'h6666, 1'b1, 8'd4},
    {1'b1, 1'b0, 8'h0F, 8'd4,  16'h7777, 1'b1, 8'd4}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] mk_ctrl(input logic [7:0] op, input logic [7:0] bc,
                                          input logic ie, input logic go);
    return {go, 6'b0, ie, 3'b0, op[4:0], 8'b0, bc};
  endfunction

  function automatic logic is_read_op(input logic [7:0] op);
    return (op == 8'h04) || (op == 8'h12) || (op == 8'h14) || (op == 8'h1C);
  endfunction

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 300; i++) begin
      rd(5'd0, s);
      if (!s[0]) break;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; port_i2c = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(5'd0, d); check("R1 status", d, 32'h0);
    rd(5'd1, d); check("R1 control", d, 32'h0);
    rd(5'd2, d); check("R1 target", d, 32'h0);
    rd(5'd3, d); check("R1 wrrd", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // table of commands (R3 R4 R7 R8 R12)
    for (int v = 0; v < NV; v++) begin
      logic [42:0] e;
      logic [7:0]  op, bc, xbc;
      logic [15:0] tg;
      logic        xerr;
      e = VEC[v];
      op = e[40:33]; bc = e[32:25]; tg = e[24:9]; xerr = e[8]; xbc = e[7:0];
      port_i2c = e[42];
      wr(5'd3, {e[41], 23'b0, 8'd4});
      wr(5'd2, {16'b0, tg});
      wr(5'd1, mk_ctrl(op, bc, 1'b0, 1'b1));
      wait_idle();
      rd(5'd0, d);
      check($sformatf("R3 R7 R8 status vec%0d", v), d, {29'b0, 1'b1, xerr, 1'b0});
      rd(5'd1, d);
      check($sformatf("R4 R12 control vec%0d", v), d, mk_ctrl(op, xbc, 1'b0, 1'b0));
      if (!xerr && is_read_op(op)) begin
        for (int i = 0; i < (int'(xbc) + 3) / 4; i++) begin
          rd(5'(8 + i), d);
          check($sformatf("R4 window vec%0d word%0d", v, i), d, {tg, op, 8'(i)});
        end
      end
      wr(5'd0, 32'h6);
    end

    // R2 write-one-to-clear
    port_i2c = 1'b0;
    wr(5'd1, mk_ctrl(8'h18, 8'd4, 1'b0, 1'b1));
    rd(5'd0, d); check("R7 SPI rejects 0x18", d, 32'h6);
    wr(5'd0, 32'h0);
    rd(5'd0, d); check("R2 zero write no effect", d, 32'h6);
    wr(5'd0, 32'h2);
    rd(5'd0, d); check("R2 clear error only", d, 32'h4);
    wr(5'd0, 32'h1);
    rd(5'd0, d); check("R2 busy not writable", d, 32'h4);
    wr(5'd0, 32'h4);
    rd(5'd0, d); check("R2 clear done", d, 32'h0);

    // R10 R5 R6 writes while busy are ignored
    wr(5'd2, 32'h0000_1357);
    wr(5'd13, 32'h0102_0304);
    rd(5'd13, d); check("R10 idle window write", d, 32'h0102_0304);
    wr(5'd1, mk_ctrl(8'h06, 8'd8, 1'b0, 1'b1));
    wr(5'd13, 32'hDEAD_BEEF);
    wr(5'd1, mk_ctrl(8'h04, 8'd20, 1'b1, 1'b1));
    wr(5'd2, 32'h0000_9999);
    wr(5'd3, {1'b1, 23'b0, 8'd12});
    wait_idle();
    rd(5'd13, d); check("R10 R5 window kept", d, 32'h0102_0304);
    rd(5'd1, d); check("R6 R5 control kept", d, mk_ctrl(8'h06, 8'd8, 1'b0, 1'b0));
    rd(5'd2, d); check("R6 target kept", d, 32'h0000_1357);
    rd(5'd3, d); check("R6 wrrd kept", d, {1'b0, 23'b0, 8'd4});
    rd(5'd0, d); check("R6 single completion", d, 32'h4);
    wr(5'd0, 32'h6);

    // R11 R9 completion collides with a clear of done
    wr(5'd2, 32'h0000_0ABC);
    wr(5'd1, mk_ctrl(8'h04, 8'd32, 1'b1, 1'b1));
    check("R9 irq low while busy", {31'b0, irq}, 32'h0);
    repeat (LAT + NW) @(negedge clk);
    wr(5'd0, 32'h6);
    check("R9 R11 irq after collision", {31'b0, irq}, 32'h1);
    rd(5'd0, d); check("R11 done survives clear", d, 32'h4);
    rd(5'd15, d); check("R4 last word", d, {16'h0ABC, 8'h04, 8'd7});
    wr(5'd0, 32'h4);
    check("R9 irq drops with done", {31'b0, irq}, 32'h0);

    summary();
    $finish;
  end
endmodule